// File: doc/BRIEF.md
# Glitch-Free Synchronous Clock Stop Controller

This block sits between the clock sources of a clock generator and its output pins. It gates a group of differential CPU clock pairs and two groups of single-ended PCI clocks in response to active-low stop requests and a power-down request. Every output stops and restarts only while its clock sits at the level where it parks. No output ever shows a shortened or stretched pulse.

Register bits, held steady by a register block outside this design, choose three things for each output. The first is whether the output is enabled at all. The second is whether a CPU pair keeps running through a CPU stop. The third is whether a free-runnable PCI output obeys the PCI stop. The PCI stop takes effect when either its pin or its register bit is low. For the CPU pairs, analog drive strengths are reported as a 2-bit state code per pair: 0 running, 1 parked by stop or disable (strong drive), 2 parked by power-down (weak drive), 3 undriven.

Top module: `clkstop_ctrl`

## Requirements
- R1: A low level on `cpu_stop_n` reaches a stoppable, enabled CPU pair only after it has been sampled on two falling edges of `cpu_clk_i`. The pair's state code changes on the rising edge that follows the second of those falling edges and not before.
- R2: A CPU pair parked with code 1 or code 2 drives `cpu_t` high and `cpu_c` low.
- R3: A CPU pair whose `cpu_free` bit is 1 keeps running (code 0) while `cpu_stop_n` is low, as long as it is enabled and `pd_n` is high.
- R4: After `cpu_stop_n` returns high, a stopped pair returns to code 0 on the rising edge that follows the second falling edge sampling the release. Its first high phase then lasts a full half period.
- R5: PCI outputs stop in the low state. The stop is effective whenever `pci_stop_n` AND `pci_run_bit` is 0.
- R6: A free-runnable output with its `pcif_stoppable` bit at 0 ignores the PCI stop, and with the bit at 1 it obeys the stop. Plain PCI outputs always obey the PCI stop.
- R7: After the effective PCI stop is released, a stopped output's first high phase begins at the third rising edge of `pci_clk_i` after the release and lasts a full half period.
- R8: An enable bit of 0 holds a single-ended output low. With `pd_n` high, it parks a CPU pair with code 1, regardless of the stop inputs.
- R9: With `pd_n` high and the CPU stop in effect, a stoppable enabled pair takes code 1 when `tri_stop_sel` is 0. It takes code 3 when `tri_stop_sel` is 1. Code 3 drives both `cpu_t` and `cpu_c` low as the logic image of high impedance.
- R10: `pd_n` low, after the same two-falling-edge sampling as R1, parks every CPU pair, including free-running ones. The code is 3 if `tri_pd_sel` or `tri_stop_sel` is 1, and 2 otherwise.
- R11: During reset, every CPU pair shows code 1 (`cpu_t` high, `cpu_c` low) and every PCI output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | Free-running CPU clock source |
| pci_clk_i | input | 1 | Free-running PCI clock source |
| cpu_stop_n | input | 1 | Active-low CPU stop request pin |
| pd_n | input | 1 | Active-low power-down request |
| pci_stop_n | input | 1 | Active-low PCI stop request pin |
| pci_run_bit | input | 1 | Register bit ANDed with `pci_stop_n`; 0 stops PCI |
| tri_pd_sel | input | 1 | 1: pairs go undriven during power-down |
| tri_stop_sel | input | 1 | 1: pairs go undriven during stop and power-down |
| cpu_free | input | N_CPU | Per pair: 1 ignores the CPU stop |
| cpu_en | input | N_CPU | Per pair enable |
| pci_en | input | N_PCI | Per plain PCI output enable |
| pcif_en | input | N_PCIF | Per free-runnable PCI output enable |
| pcif_stoppable | input | N_PCIF | Per free-runnable output: 1 obeys the PCI stop |
| cpu_t | output | N_CPU | True CPU clock outputs |
| cpu_c | output | N_CPU | Complement CPU clock outputs |
| cpu_state | output | 2*N_CPU | Per pair state code, pair i in bits [2i+1:2i] |
| pci_o | output | N_PCI | Plain PCI clock outputs |
| pcif_o | output | N_PCIF | Free-runnable PCI clock outputs |

## Verification
The hardest case to reach is the exact moment a stop or release lands. That moment is when the request has passed one sampling edge but not the second, and the output must still be running or still be parked. The stimulus changes the request two time units after a falling edge. It then checks the state code right after each of the next rising edges, and it samples the first restored high phase near its end. For PCI, it checks the third rising edge after the release. Randomised configurations then cover the priority order among power-down, enable, free-run and the tri-state selects.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  typedef enum logic [1:0] {
    CS_RUN       = 2'd0,
    CS_PARK_STOP = 2'd1,
    CS_PARK_PD   = 2'd2,
    CS_HIZ       = 2'd3
  } cpu_state_e;

  // Next state of one CPU pair; power-down outranks enable, enable outranks stop.
  function automatic cpu_state_e cpu_next(input logic pd_on,
                                          input logic stop_on,
                                          input logic free,
                                          input logic en,
                                          input logic tri_pd,
                                          input logic tri_stop);
    if (pd_on)
      return (tri_pd | tri_stop) ? CS_HIZ : CS_PARK_PD;
    if (!en)
      return CS_PARK_STOP;
    if (stop_on && !free)
      return tri_stop ? CS_HIZ : CS_PARK_STOP;
    return CS_RUN;
  endfunction

  // Gate enable of one single-ended output.
  function automatic logic se_gate(input logic en,
                                   input logic stoppable,
                                   input logic run);
    return en & (run | ~stoppable);
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int   STAGES  = 2,
  parameter bit   ON_FALL = 1'b1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shift_q;

  generate
    if (ON_FALL) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= {STAGES{RST_VAL}};
        else        shift_q <= {shift_q[STAGES-2:0], d};
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= {STAGES{RST_VAL}};
        else        shift_q <= {shift_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = shift_q[STAGES-1];
endmodule

// File: rtl/clkstop_cpu_pair.sv
`timescale 1ns/1ps
module clkstop_cpu_pair
  import clkstop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_on,
  input  logic       stop_on,
  input  logic       free,
  input  logic       en,
  input  logic       tri_pd,
  input  logic       tri_stop,
  output logic       out_t,
  output logic       out_c,
  output logic [1:0] st
);
  cpu_state_e state_q;

  // State moves only on the rising edge, while the true clock is already high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_PARK_STOP;
    else        state_q <= cpu_next(pd_on, stop_on, free, en, tri_pd, tri_stop);
  end

  always_comb begin
    case (state_q)
      CS_RUN:  begin out_t = clk;  out_c = ~clk; end
      CS_HIZ:  begin out_t = 1'b0; out_c = 1'b0; end
      default: begin out_t = 1'b1; out_c = 1'b0; end
    endcase
  end

  assign st = state_q;
endmodule

// File: rtl/clkstop_se_bank.sv
`timescale 1ns/1ps
module clkstop_se_bank
  import clkstop_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] en,
  input  logic [W-1:0] stoppable,
  output logic [W-1:0] out
);
  logic [W-1:0] gate_q;

  // Enables move on the falling edge, while the clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= '0;
    else
      for (int i = 0; i < W; i++)
        gate_q[i] <= se_gate(en[i], stoppable[i], run);
  end

  assign out = gate_q & {W{clk}};
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl #(
  parameter int N_CPU     = 3,
  parameter int N_PCI     = 7,
  parameter int N_PCIF    = 3,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 rst_n,
  input  logic                 cpu_clk_i,
  input  logic                 pci_clk_i,
  input  logic                 cpu_stop_n,
  input  logic                 pd_n,
  input  logic                 pci_stop_n,
  input  logic                 pci_run_bit,
  input  logic                 tri_pd_sel,
  input  logic                 tri_stop_sel,
  input  logic [N_CPU-1:0]     cpu_free,
  input  logic [N_CPU-1:0]     cpu_en,
  input  logic [N_PCI-1:0]     pci_en,
  input  logic [N_PCIF-1:0]    pcif_en,
  input  logic [N_PCIF-1:0]    pcif_stoppable,
  output logic [N_CPU-1:0]     cpu_t,
  output logic [N_CPU-1:0]     cpu_c,
  output logic [2*N_CPU-1:0]   cpu_state,
  output logic [N_PCI-1:0]     pci_o,
  output logic [N_PCIF-1:0]    pcif_o
);
  localparam logic [N_PCI-1:0] PCI_ALWAYS_STOP = '1;

  // Named internal events, observed by the checker.
  logic cpu_run_seen;
  logic pd_seen;
  logic pci_run_seen;
  logic pci_run_req;

  assign pci_run_req = pci_stop_n & pci_run_bit;

  clkstop_sync #(.STAGES(SYNC_DEPTH), .ON_FALL(1'b1), .RST_VAL(1'b1)) u_cpu_stop_sync (
    .clk(cpu_clk_i), .rst_n(rst_n), .d(cpu_stop_n), .q(cpu_run_seen));

  clkstop_sync #(.STAGES(SYNC_DEPTH), .ON_FALL(1'b1), .RST_VAL(1'b1)) u_pd_sync (
    .clk(cpu_clk_i), .rst_n(rst_n), .d(pd_n), .q(pd_seen));

  clkstop_sync #(.STAGES(SYNC_DEPTH), .ON_FALL(1'b0), .RST_VAL(1'b1)) u_pci_stop_sync (
    .clk(pci_clk_i), .rst_n(rst_n), .d(pci_run_req), .q(pci_run_seen));

  generate
    for (genvar i = 0; i < N_CPU; i++) begin : g_pair
      clkstop_cpu_pair u_pair (
        .clk      (cpu_clk_i),
        .rst_n    (rst_n),
        .pd_on    (~pd_seen),
        .stop_on  (~cpu_run_seen),
        .free     (cpu_free[i]),
        .en       (cpu_en[i]),
        .tri_pd   (tri_pd_sel),
        .tri_stop (tri_stop_sel),
        .out_t    (cpu_t[i]),
        .out_c    (cpu_c[i]),
        .st       (cpu_state[2*i +: 2])
      );
    end
  endgenerate

  clkstop_se_bank #(.W(N_PCI)) u_pci_bank (
    .clk(pci_clk_i), .rst_n(rst_n), .run(pci_run_seen),
    .en(pci_en), .stoppable(PCI_ALWAYS_STOP), .out(pci_o));

  clkstop_se_bank #(.W(N_PCIF)) u_pcif_bank (
    .clk(pci_clk_i), .rst_n(rst_n), .run(pci_run_seen),
    .en(pcif_en), .stoppable(pcif_stoppable), .out(pcif_o));

endmodule

// File: rtl/clkstop_ctrl_chk.sv
`timescale 1ns/1ps
module clkstop_ctrl_chk #(
  parameter int N_CPU  = 3,
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3
) (
  input logic                 cpu_clk_i,
  input logic                 pci_clk_i,
  input logic                 rst_n,
  input logic                 cpu_run_seen,
  input logic                 pd_seen,
  input logic                 pci_run_seen,
  input logic                 tri_stop_sel,
  input logic [N_CPU-1:0]     cpu_free,
  input logic [N_CPU-1:0]     cpu_en,
  input logic [N_CPU-1:0]     cpu_t,
  input logic [N_CPU-1:0]     cpu_c,
  input logic [2*N_CPU-1:0]   cpu_state,
  input logic [N_PCI-1:0]     pci_en,
  input logic [N_PCI-1:0]     pci_o,
  input logic [N_PCIF-1:0]    pcif_en,
  input logic [N_PCIF-1:0]    pcif_stoppable,
  input logic [N_PCIF-1:0]    pcif_o
);
  generate
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_chk
      p_park_levels_r2: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
        (cpu_state[2*i +: 2] == 2'd1 || cpu_state[2*i +: 2] == 2'd2) |-> (cpu_t[i] && !cpu_c[i]));

      p_free_ignores_stop_r3: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
        $past(rst_n && pd_seen && cpu_free[i] && cpu_en[i]) |-> (cpu_state[2*i +: 2] == 2'd0));

      p_stop_tristate_r9: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
        $past(rst_n && pd_seen && !cpu_run_seen && !cpu_free[i] && cpu_en[i] && tri_stop_sel)
        |-> (cpu_state[2*i +: 2] == 2'd3));

      p_hiz_undriven_r9: assert property (@(posedge cpu_clk_i) disable iff (!rst_n)
        (cpu_state[2*i +: 2] == 2'd3) |-> (!cpu_t[i] && !cpu_c[i]));
    end

    for (genvar j = 0; j < N_PCI; j++) begin : g_pci_chk
      p_pci_stop_low_r5: assert property (@(negedge pci_clk_i) disable iff (!rst_n)
        $past(rst_n && !pci_run_seen) |-> !pci_o[j]);

      p_pci_disabled_low_r8: assert property (@(negedge pci_clk_i) disable iff (!rst_n)
        $past(rst_n && !pci_en[j]) |-> !pci_o[j]);
    end

    for (genvar k = 0; k < N_PCIF; k++) begin : g_pcif_chk
      p_pcif_free_runs_r6: assert property (@(negedge pci_clk_i) disable iff (!rst_n)
        $past(rst_n && pcif_en[k] && !pcif_stoppable[k]) |-> pcif_o[k]);
    end
  endgenerate
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_PCIF(N_PCIF)) u_chk (
  .cpu_clk_i(cpu_clk_i), .pci_clk_i(pci_clk_i), .rst_n(rst_n),
  .cpu_run_seen(cpu_run_seen), .pd_seen(pd_seen), .pci_run_seen(pci_run_seen),
  .tri_stop_sel(tri_stop_sel), .cpu_free(cpu_free), .cpu_en(cpu_en),
  .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_state(cpu_state),
  .pci_en(pci_en), .pci_o(pci_o), .pcif_en(pcif_en),
  .pcif_stoppable(pcif_stoppable), .pcif_o(pcif_o));

// File: tb/clkstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PCI_PERIOD = 30;
  localparam int NC = 3;
  localparam int NP = 7;
  localparam int NF = 3;

  logic rst_n = 1'b0;
  logic cpu_clk_i = 1'b0;
  logic pci_clk_i = 1'b0;
  logic cpu_stop_n = 1'b1, pd_n = 1'b1, pci_stop_n = 1'b1, pci_run_bit = 1'b1;
  logic tri_pd_sel = 1'b0, tri_stop_sel = 1'b0;
  logic [NC-1:0] cpu_free = '0, cpu_en = '1;
  logic [NP-1:0] pci_en = '1;
  logic [NF-1:0] pcif_en = '1, pcif_stoppable = '0;
  logic [NC-1:0] cpu_t, cpu_c;
  logic [2*NC-1:0] cpu_state;
  logic [NP-1:0] pci_o;
  logic [NF-1:0] pcif_o;

  int checks = 0;
  int errors = 0;

  clkstop_ctrl #(.N_CPU(NC), .N_PCI(NP), .N_PCIF(NF)) dut_i (
    .rst_n(rst_n), .cpu_clk_i(cpu_clk_i), .pci_clk_i(pci_clk_i),
    .cpu_stop_n(cpu_stop_n), .pd_n(pd_n), .pci_stop_n(pci_stop_n),
    .pci_run_bit(pci_run_bit), .tri_pd_sel(tri_pd_sel), .tri_stop_sel(tri_stop_sel),
    .cpu_free(cpu_free), .cpu_en(cpu_en), .pci_en(pci_en), .pcif_en(pcif_en),
    .pcif_stoppable(pcif_stoppable), .cpu_t(cpu_t), .cpu_c(cpu_c),
    .cpu_state(cpu_state), .pci_o(pci_o), .pcif_o(pcif_o));

  initial forever #(CLK_PERIOD/2) cpu_clk_i = ~cpu_clk_i;
  initial forever #(PCI_PERIOD/2) pci_clk_i = ~pci_clk_i;

  initial begin
    #(100000 * CLK_PERIOD);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected code per the requirement list (R8, R9, R10 priority).
  function automatic int model_code(logic pdn, logic stn, logic fr, logic en, logic tp, logic ts);
    int code;
    code = 0;
    if (pdn) begin
      if (!en) code = 1;
      else if (!stn && !fr) code = ts ? 3 : 1;
    end else begin
      code = (tp || ts) ? 3 : 2;
    end
    return code;
  endfunction

  function automatic string cpu_tag(logic pdn, logic stn, logic fr, logic en, logic ts);
    if (!pdn) return "R10";
    if (!en) return "R8";
    if (!stn && fr) return "R3";
    if (!stn && ts) return "R9";
    if (!stn) return "R2";
    return "R4";
  endfunction

  task automatic steady_check();
    int code;
    logic run;
    repeat (4) @(posedge pci_clk_i);
    @(posedge cpu_clk_i); #1;
    for (int i = 0; i < NC; i++) begin
      code = model_code(pd_n, cpu_stop_n, cpu_free[i], cpu_en[i], tri_pd_sel, tri_stop_sel);
      check(int'(cpu_state[2*i +: 2]) == code, cpu_tag(pd_n, cpu_stop_n, cpu_free[i], cpu_en[i], tri_stop_sel),
            "cpu state code", int'(cpu_state[2*i +: 2]), code);
      check(cpu_t[i] == (code != 3), "R2", "cpu_t high phase", int'(cpu_t[i]), int'(code != 3));
      check(cpu_c[i] == 1'b0, "R2", "cpu_c high phase", int'(cpu_c[i]), 0);
    end
    @(negedge cpu_clk_i); #1;
    for (int i = 0; i < NC; i++) begin
      code = model_code(pd_n, cpu_stop_n, cpu_free[i], cpu_en[i], tri_pd_sel, tri_stop_sel);
      check(cpu_t[i] == (code == 1 || code == 2), "R2", "cpu_t low phase", int'(cpu_t[i]), int'(code == 1 || code == 2));
      check(cpu_c[i] == (code == 0), "R2", "cpu_c low phase", int'(cpu_c[i]), int'(code == 0));
    end
    run = pci_stop_n & pci_run_bit;
    @(posedge pci_clk_i); #2;
    for (int j = 0; j < NP; j++)
      check(pci_o[j] == (pci_en[j] & run), pci_en[j] ? "R5" : "R8", "pci high phase",
            int'(pci_o[j]), int'(pci_en[j] & run));
    for (int k = 0; k < NF; k++)
      check(pcif_o[k] == (pcif_en[k] & (run | ~pcif_stoppable[k])), pcif_en[k] ? "R6" : "R8",
            "pcif high phase", int'(pcif_o[k]), int'(pcif_en[k] & (run | ~pcif_stoppable[k])));
    @(negedge pci_clk_i); #2;
    check(pci_o == '0 && pcif_o == '0, "R5", "pci low phase", int'({pci_o, pcif_o}), 0);
  endtask

  initial begin
    void'($urandom(32'h00C1_0C57));
    // R11: reset state
    #23;
    check(cpu_state == {NC{2'd1}}, "R11", "reset cpu codes", int'(cpu_state), int'({NC{2'd1}}));
    check(cpu_t == '1 && cpu_c == '0, "R11", "reset cpu levels", int'({cpu_t, cpu_c}), int'({{NC{1'b1}}, {NC{1'b0}}}));
    @(posedge pci_clk_i); #2;
    check(pci_o == '0 && pcif_o == '0, "R11", "reset pci low", int'({pci_o, pcif_o}), 0);
    @(negedge cpu_clk_i); #2;
    rst_n = 1'b1;
    steady_check();

    // R1: stop latency
    @(negedge cpu_clk_i); #2 cpu_stop_n = 1'b0;
    @(negedge cpu_clk_i); @(posedge cpu_clk_i); #1;
    check(cpu_state[1:0] == 2'd0, "R1", "still running after one sample", int'(cpu_state[1:0]), 0);
    @(negedge cpu_clk_i); @(posedge cpu_clk_i); #1;
    check(cpu_state[1:0] == 2'd1, "R1", "parked after two samples", int'(cpu_state[1:0]), 1);
    check(cpu_t[0] && !cpu_c[0], "R1", "park levels", int'({cpu_t[0], cpu_c[0]}), 2);

    // R4: release latency and full first pulse
    @(negedge cpu_clk_i); #2 cpu_stop_n = 1'b1;
    @(negedge cpu_clk_i); @(posedge cpu_clk_i); #1;
    check(cpu_state[1:0] == 2'd1, "R4", "still parked after one sample", int'(cpu_state[1:0]), 1);
    @(negedge cpu_clk_i); @(posedge cpu_clk_i); #1;
    check(cpu_state[1:0] == 2'd0, "R4", "running after two samples", int'(cpu_state[1:0]), 0);
    #(CLK_PERIOD/2 - 2);
    check(cpu_t[0] == 1'b1, "R4", "first high phase full width", int'(cpu_t[0]), 1);
    @(negedge cpu_clk_i); #1;
    check(cpu_t[0] == 1'b0 && cpu_c[0] == 1'b1, "R4", "first low phase", int'({cpu_t[0], cpu_c[0]}), 1);

    // R7: PCI restart timing
    pcif_stoppable = '1;
    @(negedge pci_clk_i); #2 pci_stop_n = 1'b0;
    repeat (4) @(posedge pci_clk_i);
    #2 check(pci_o == '0 && pcif_o == '0, "R5", "pin stop low", int'({pci_o, pcif_o}), 0);
    @(posedge pci_clk_i); #2 pci_stop_n = 1'b1;
    @(posedge pci_clk_i); @(posedge pci_clk_i); #2;
    check(pci_o == '0, "R7", "still stopped at second edge", int'(pci_o), 0);
    @(posedge pci_clk_i); #2;
    check(pci_o == '1 && pcif_o == '1, "R7", "running at third edge", int'({pci_o, pcif_o}), int'({(NP+NF){1'b1}}));
    #(PCI_PERIOD/2 - 4);
    check(pci_o == '1, "R7", "first high phase full width", int'(pci_o), int'({NP{1'b1}}));

    // R5/R6: register bit stop with mixed stoppability
    #3 pci_run_bit = 1'b0; pcif_stoppable = 3'b010;
    steady_check();
    pci_run_bit = 1'b1;

    // R9, R10 directed
    cpu_free = 3'b100; tri_stop_sel = 1'b1; cpu_stop_n = 1'b0;
    steady_check();
    tri_stop_sel = 1'b0; pd_n = 1'b0;
    steady_check();
    tri_pd_sel = 1'b1;
    steady_check();
    pd_n = 1'b1; tri_pd_sel = 1'b0; cpu_stop_n = 1'b1; cpu_free = '0;

    // Constrained random configurations
    for (int n = 0; n < 40; n++) begin
      @(negedge cpu_clk_i); #2;
      cpu_stop_n     = ($urandom % 3) != 0;
      pd_n           = ($urandom % 5) != 0;
      pci_stop_n     = ($urandom % 3) != 0;
      pci_run_bit    = ($urandom % 4) != 0;
      tri_pd_sel     = $urandom % 2;
      tri_stop_sel   = $urandom % 2;
      cpu_free       = $urandom;
      cpu_en         = $urandom | $urandom;
      pci_en         = $urandom | $urandom;
      pcif_en        = $urandom | $urandom;
      pcif_stoppable = $urandom;
      steady_check();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule